// File: doc/BRIEF.md
# Segmented Byte-to-Word Packer

This block turns a byte stream, split into segments of any byte length, into a stream of 32-bit words for a sink that cannot mask off bytes. Every word it presents is full, except the single word that closes a message. Bytes that are left over at the end of a segment are not sent on their own. They stay in the packing lanes and are completed with the first bytes of the segments that follow. A segment that is too short to finish a word is used up entirely, and collection carries on into the next segment. After a word has been completed this way, packing continues from the current position in the segment.

A message begins with a one-cycle start pulse. The pulse carries the message's total byte length. Bytes then arrive over a valid/ready handshake, and each byte is tagged with a segment-end flag and a message-end flag. When the message is 64 bytes or longer, its words are marked as grouped into bursts of four, and a flag marks the first word of each group. Shorter messages go out as single words with no grouping marks. When the final word has been taken, or when the message length is zero, a done strobe is raised for one cycle.

Top module: `wp_word_packer`

## Requirements
- R1: Bytes are packed little-endian. The first byte of each group of four goes to out_data_o[7:0], the second to [15:8], the third to [23:16] and the fourth to [31:24].
- R2: Segment ends do not affect packing. A remainder of 0 to 3 bytes at the end of a segment is completed with bytes from the following segment or segments, including segments of a single byte. The message's words are therefore the message bytes, taken four at a time in arrival order.
- R3: Only the final word of a message may hold fewer than 4 bytes. out_bytes_o gives the number of valid bytes, from 1 to 4, and out_last_o is 1 only on the final word. Unused byte lanes read as zero.
- R4: When the start length is 64 or more, out_burst_o is 1 on every word, and out_burst_first_o is 1 on words 0, 4, 8 and so on. When the start length is below 64, both flags are 0.
- R5: A start pulse with length 0 produces no output word. done_o is 1 during the cycle after the start edge and 0 in the cycle after that.
- R6: done_o is 1 during the cycle after the edge on which the final word is handed over, and no further word follows.
- R7: While out_valid_o is 1 and out_ready_i is 0, in_ready_o is 0. In the next cycle out_valid_o stays 1 and the word and its flags are unchanged.
- R8: During reset and straight after it, out_valid_o, in_ready_o and done_o are 0.
- R9: in_ready_o is 0 when no message is open, so bytes presented without a start pulse are not taken and do not appear in any later word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a message; accepted when no message is open |
| msg_len_i | input | LEN_W | Message byte length, sampled with start_i |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted on this edge when valid |
| in_data_i | input | 8 | Input byte |
| in_seg_end_i | input | 1 | Byte is the last byte of its segment |
| in_msg_end_i | input | 1 | Byte is the last byte of the message |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Sink takes the word |
| out_data_o | output | 32 | Packed word, little-endian |
| out_bytes_o | output | 3 | Valid bytes in the word, 1 to 4 |
| out_last_o | output | 1 | Final word of the message |
| out_burst_o | output | 1 | Message uses burst grouping |
| out_burst_first_o | output | 1 | Word opens a burst group |
| done_o | output | 1 | One-cycle message-complete strobe |

## Verification
The assertions check, on every cycle, the rules that relate port values to one another. A short word must also be the final word, and a presented word always holds at least one byte. A stalled word must stay unchanged, and no word is presented while no message is open. A burst-first mark never appears without burst mode. Whether the bytes land in the right lanes after a remainder has been carried across segments of different lengths can only be shown by the bench's message scenarios. The same holds for the burst marks falling on every fourth word, and for done coming in the right cycle, because each of these depends on the byte history over a whole message.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_W     = 8 * WORD_BYTES;
  localparam int unsigned LANE_W     = $clog2(WORD_BYTES);
  localparam int unsigned BCNT_W     = $clog2(WORD_BYTES + 1);

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic [BCNT_W-1:0] nbytes;
    logic              last;
  } word_t;
endpackage

// File: rtl/wp_lane_pack.sv
module wp_lane_pack
  import wp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       take_i,
  input  logic [7:0] byte_i,
  input  logic       end_i,
  output logic       word_vld_o,
  output word_t      word_o
);
  logic [LANE_W-1:0] lane_q;
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] merged;

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign merged[8*g +: 8] = (lane_q == LANE_W'(g)) ? byte_i : acc_q[8*g +: 8];
  end

  assign word_vld_o    = take_i & ((lane_q == LANE_W'(WORD_BYTES - 1)) | end_i);
  assign word_o.data   = merged;
  assign word_o.nbytes = BCNT_W'(lane_q) + BCNT_W'(1);
  assign word_o.last   = end_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q <= '0;
      acc_q  <= '0;
    end else if (clr_i || word_vld_o) begin
      lane_q <= '0;
      acc_q  <= '0;
    end else if (take_i) begin
      lane_q <= lane_q + LANE_W'(1);
      acc_q  <= merged;
    end
  end
endmodule

// File: rtl/wp_group_tag.sv
module wp_group_tag #(
  parameter int unsigned LEN_W           = 16,
  parameter int unsigned BURST_WORDS     = 4,
  parameter int unsigned BURST_MIN_BYTES = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             adv_i,
  output logic             burst_o,
  output logic             first_o
);
  localparam int unsigned IDX_W = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;

  logic [IDX_W-1:0] idx_q;
  logic             mode_q;

  assign burst_o = mode_q;
  assign first_o = mode_q & (idx_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      mode_q <= 1'b0;
    end else if (start_i) begin
      idx_q  <= '0;
      mode_q <= (len_i >= LEN_W'(BURST_MIN_BYTES));
    end else if (adv_i) begin
      idx_q  <= (idx_q == IDX_W'(BURST_WORDS - 1)) ? '0 : idx_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/wp_word_packer.sv
module wp_word_packer
  import wp_pkg::*;
#(
  parameter int unsigned LEN_W           = 16,
  parameter int unsigned BURST_WORDS     = 4,
  parameter int unsigned BURST_MIN_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  msg_len_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [7:0]        in_data_i,
  input  logic              in_seg_end_i,
  input  logic              in_msg_end_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic [BCNT_W-1:0] out_bytes_o,
  output logic              out_last_o,
  output logic              out_burst_o,
  output logic              out_burst_first_o,
  output logic              done_o
);
  logic  busy_q, tail_q, out_valid_q, first_q, done_q;
  word_t out_q, word_c;
  logic  word_vld, take, start_ok, stall, tag_first, out_fire;

  assign start_ok = start_i & ~busy_q;
  assign stall    = out_valid_q & ~out_ready_i;
  assign in_ready_o = busy_q & ~tail_q & ~stall;
  assign take     = in_valid_i & in_ready_o;
  assign out_fire = out_valid_q & out_ready_i;

  wp_lane_pack i_pack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start_ok),
    .take_i     (take),
    .byte_i     (in_data_i),
    .end_i      (in_msg_end_i),
    .word_vld_o (word_vld),
    .word_o     (word_c)
  );

  wp_group_tag #(
    .LEN_W           (LEN_W),
    .BURST_WORDS     (BURST_WORDS),
    .BURST_MIN_BYTES (BURST_MIN_BYTES)
  ) i_tag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_ok),
    .len_i   (msg_len_i),
    .adv_i   (word_vld),
    .burst_o (out_burst_o),
    .first_o (tag_first)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      tail_q      <= 1'b0;
      out_valid_q <= 1'b0;
      out_q       <= '0;
      first_q     <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= (start_ok && msg_len_i == '0) || (out_fire && out_q.last);
      if (start_ok) begin
        busy_q <= (msg_len_i != '0);
        tail_q <= 1'b0;
      end else begin
        if (out_fire && out_q.last) busy_q <= 1'b0;
        if (take && in_msg_end_i)   tail_q <= 1'b1;
      end
      if (word_vld) begin
        out_valid_q <= 1'b1;
        out_q       <= word_c;
        first_q     <= tag_first;
      end else if (out_ready_i) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  assign out_valid_o       = out_valid_q;
  assign out_data_o        = out_q.data;
  assign out_bytes_o       = out_q.nbytes;
  assign out_last_o        = out_q.last;
  assign out_burst_first_o = first_q;
  assign done_o            = done_q;

  AST_SHORT_ONLY_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_q && out_q.nbytes != BCNT_W'(WORD_BYTES) |-> out_q.last); // R3
  AST_BYTES_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_q |-> out_q.nbytes != '0); // R3
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_q && !out_ready_i |=> out_valid_q && $stable(out_q) && $stable(first_q)); // R7
  AST_FIRST_NEEDS_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_q && first_q |-> out_burst_o); // R4
  AST_NO_WORD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !out_valid_q); // R9
  AST_MSG_END_CLOSES_SEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_msg_end_i |-> in_seg_end_i); // R2
endmodule

// File: tb/test_wp_word_packer.sv
module test_wp_word_packer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] msg_len_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [7:0]  in_data_i = '0;
  logic        in_seg_end_i = 1'b0;
  logic        in_msg_end_i = 1'b0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [31:0] out_data_o;
  logic [2:0]  out_bytes_o;
  logic        out_last_o, out_burst_o, out_burst_first_o, done_o;

  int checks = 0;
  int failures = 0;

  always #2 clk_i = ~clk_i;

  wp_word_packer i_wp_word_packer (.*);

  // len, segment length A, segment length B, stall mode
  localparam int NV = 11;
  localparam int VEC [NV][4] = '{
    '{7, 3, 1, 0}, '{12, 5, 2, 1}, '{1, 1, 1, 0}, '{4, 4, 4, 0},
    '{16, 1, 1, 1}, '{63, 6, 3, 0}, '{64, 10, 7, 1}, '{70, 2, 5, 2},
    '{9, 3, 3, 1}, '{5, 2, 2, 0}, '{13, 1, 2, 2}};

  function automatic logic [7:0] pat(int m, int i);
    return 8'((m * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic start_msg(input int len);
    @(negedge clk_i);
    start_i = 1'b1;
    msg_len_i = 16'(len);
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic send_msg(input int m, input int len, input int sa, input int sb);
    int seg_left = sa;
    bit use_b = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk_i);
      in_valid_i = 1'b1;
      in_data_i = pat(m, i);
      in_msg_end_i = (i == len - 1);
      in_seg_end_i = (seg_left == 1) || (i == len - 1);
      #1;
      while (!in_ready_o) begin
        @(negedge clk_i);
        #1;
      end
      if (seg_left == 1) begin
        use_b = ~use_b;
        seg_left = use_b ? sb : sa;
      end else begin
        seg_left--;
      end
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    in_msg_end_i = 1'b0;
    in_seg_end_i = 1'b0;
  endtask

  task automatic recv_msg(input int m, input int len, input int mode);
    int nw = (len + 3) / 4;
    int j = 0;
    int cyc = 0;
    bit was_stall = 1'b0;
    logic [31:0] held = '0;
    while (j < nw) begin
      @(negedge clk_i);
      out_ready_i = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 2 == 1) : (cyc % 3 == 0);
      cyc++;
      #1;
      if (was_stall)
        check(out_valid_o && out_data_o == held, "R7", "stalled word held", out_data_o, held);
      was_stall = 1'b0;
      if (out_valid_o && out_ready_i) begin
        logic [31:0] ed = '0;
        int eb = (len - 4 * j > 4) ? 4 : len - 4 * j;
        bit el = (j == nw - 1);
        bit eburst = (len >= 64);
        bit efirst = eburst && (j % 4 == 0);
        for (int b = 0; b < 4; b++)
          if (4 * j + b < len) ed[8*b +: 8] = pat(m, 4 * j + b);
        check(out_data_o == ed, "R1 R2", "word data", out_data_o, ed);
        check(out_bytes_o == 3'(eb) && out_last_o == el, "R3", "bytes/last",
              {out_bytes_o, out_last_o}, {3'(eb), el});
        check(out_burst_o == eburst && out_burst_first_o == efirst, "R4", "burst flags",
              {out_burst_o, out_burst_first_o}, {eburst, efirst});
        j++;
      end else if (out_valid_o) begin
        check(!in_ready_o, "R7", "input held off while stalled", in_ready_o, 0);
        was_stall = 1'b1;
        held = out_data_o;
      end
    end
    @(negedge clk_i);
    out_ready_i = 1'b1;
    #1;
    check(done_o && !out_valid_o, "R6", "done after final word", {done_o, out_valid_o}, 2'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    #1;
    check(!out_valid_o && !in_ready_o && !done_o, "R8", "outputs in reset",
          {out_valid_o, in_ready_o, done_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    check(!out_valid_o && !in_ready_o && !done_o, "R8", "outputs after reset",
          {out_valid_o, in_ready_o, done_o}, 0);

    // R9: bytes offered with no open message
    in_valid_i = 1'b1;
    in_data_i = 8'hEE;
    in_seg_end_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      #1;
      check(!in_ready_o && !out_valid_o, "R9", "idle refuses bytes",
            {in_ready_o, out_valid_o}, 0);
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    in_seg_end_i = 1'b0;

    for (int v = 0; v < NV; v++) begin
      start_msg(VEC[v][0]);
      fork
        send_msg(v, VEC[v][0], VEC[v][1], VEC[v][2]);
        recv_msg(v, VEC[v][0], VEC[v][3]);
      join
      @(negedge clk_i);
      #1;
      check(!done_o && !out_valid_o, "R6", "no extra word or done", {done_o, out_valid_o}, 0);
    end

    // R5: zero-length message
    start_msg(0);
    #1;
    check(done_o && !out_valid_o, "R5", "zero length done", {done_o, out_valid_o}, 2'b10);
    @(negedge clk_i);
    #1;
    check(!done_o && !out_valid_o && !in_ready_o, "R5", "zero length done one cycle",
          {done_o, out_valid_o, in_ready_o}, 0);

    // a message after the zero-length one still packs from lane 0
    start_msg(6);
    fork
      send_msg(20, 6, 1, 2);
      recv_msg(20, 6, 2);
    join

    summary();
    $finish;
  end
endmodule